// File: doc/BRIEF.md
# Multi-Thread Interrupt Aggregator

This block gathers the pending-interrupt conditions of a set of command threads (24 by default, 16 as the other usual setting) into one global status word and a single interrupt line. The status word is active-low. A thread with an enabled interrupt pending shows a 0 in its own bit position. When nothing is pending, every valid bit reads as 1. Software reads the word, masks it with a field of ones as wide as the thread count, and services each thread whose bit is clear.

The block also decodes a word-addressed register window. The low 256 bytes form a global area. That area holds the status word, a slot-cycle register that sets the time slice the thread scheduler gives each thread, and a write-only port that clears one event token by index. Above the global area sits one register bank per thread, each 128 bytes wide. The contents of these banks live outside this block. The aggregator only raises the select line for the addressed thread, supplies the word offset inside the bank, and returns that thread's read data.

Requests enter on a valid/ready channel. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. A write completes when it is accepted and gives no response. A read produces exactly one response beat on a second valid/ready channel. That beat is held, unchanged, until `rsp_ready` takes it. While a read response is waiting, `req_ready` stays low, so at most one read is outstanding.

Top module: `thread_irq_aggregator`

## Requirements
- R1: A read of byte offset 0x10 returns the status word. For each thread n below the thread count, bit n is 0 when `thr_pend[n]` was high on the clock edge before the one that accepted the read, and 1 otherwise. Bits at and above the thread count always read 1. When no thread is pending, the masked value is all ones.
- R2: `irq_o` is high in the cycle after any `thr_pend` bit is high. It is low in the cycle after all `thr_pend` bits are low.
- R3: After reset, `irq_o` is 0, `rsp_valid` is 0, `req_ready` is 1, `slot_cycles` is 0 and `evt_tok` is all zeros.
- R4: A write to byte offset 0x30 loads the low 16 bits of the write data into `slot_cycles`. A read of 0x30 returns that value, zero-extended. `slot_cycles` changes on no other access.
- R5: A write to byte offset 0x68 clears the event token whose index equals the write data. An index at or above the event count has no effect. A read of 0x68 returns 0. If the same token is set and cleared in the same cycle, the set wins.
- R6: A high bit on `evt_set` sets the matching `evt_tok` bit on the next clock edge. The bit then stays set until it is cleared as in R5.
- R7: Byte addresses from 0x100 up to 0x100 + 0x80 × thread count address the thread banks. In the cycle a request is accepted, `thr_sel` is one-hot on thread (addr − 0x100) / 0x80 and `thr_off` carries the word offset ((addr − 0x100) mod 0x80) / 4. `thr_wr` is high for a write. A read returns word t of `thr_rdata` (bits 32t+31 down to 32t) for the selected thread t.
- R8: A request to any other address is unmapped. This includes a global offset other than 0x10, 0x30 or 0x68, an address past the last bank, and any address with a nonzero value in its low two bits. An unmapped read returns 0. An unmapped write changes no output and raises no `thr_sel` bit.
- R9: A read response becomes valid on the edge that accepts the read. It holds its data until `rsp_ready` is high on an edge. `req_ready` is low while the response waits. A write never produces a response.
- R10: A write to the status offset 0x10 changes neither the status word nor `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response offered |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | 32 | Read response data |
| thr_pend | input | 24 | Per-thread enabled interrupt pending |
| irq_o | output | 1 | Combined interrupt, active high |
| thr_sel | output | 24 | One-hot bank select, valid in the accept cycle |
| thr_off | output | 5 | Word offset inside the selected bank |
| thr_wr | output | 1 | The bank access is a write |
| thr_rdata | input | 768 | Read data of every bank, 32 bits per thread |
| slot_cycles | output | 16 | Scheduler time slice |
| evt_set | input | 32 | Event token set pulses |
| evt_tok | output | 32 | Event token state |

## Verification
`thr_pend` goes through one register before it reaches anything else. For that reason the bench checks `irq_o` at the first falling edge after it changes `thr_pend`, and it starts any status read at least one cycle after that change. Read data, `thr_sel` and `thr_off` are compared in the cycle the request is offered. The response is then checked at the falling edge after the accepting edge, and checked again one cycle later while `rsp_ready` is held low. Token sets, token clears and slot writes are all visible at the falling edge that follows their clock edge, and the bench checks them there against its own model.

// File: rtl/aggr_pkg.sv
package aggr_pkg;
  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_STATUS,
    RGN_SLOT,
    RGN_EVCLR,
    RGN_BANK
  } region_e;

  localparam int unsigned STATUS_OFS = 32'h10;
  localparam int unsigned SLOT_OFS   = 32'h30;
  localparam int unsigned EVCLR_OFS  = 32'h68;
endpackage

// File: rtl/aggr_irq_collect.sv
module aggr_irq_collect #(
  parameter int N  = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  thr_pend,
  output logic [DW-1:0] status_o,
  output logic          irq_o
);
  logic [N-1:0] pend_q;
  logic         irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= thr_pend;
      irq_q  <= |thr_pend;
    end
  end

  // Active-low status: a cleared bit marks a pending thread.
  for (genvar g = 0; g < DW; g++) begin : g_stat
    if (g < N) begin : g_live
      assign status_o[g] = ~pend_q[g];
    end else begin : g_pad
      assign status_o[g] = 1'b1;
    end
  end

  assign irq_o = irq_q;

  p_irq_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|thr_pend) |=> irq_o);
  p_irq_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|thr_pend) |=> !irq_o);
  // R1: the all-ones masked word and a quiet line go together.
  p_idle_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == !(&status_o[N-1:0]));
endmodule

// File: rtl/aggr_win_decode.sv
module aggr_win_decode
  import aggr_pkg::*;
#(
  parameter int N           = 24,
  parameter int AW          = 12,
  parameter int BANK_BASE   = 'h100,
  parameter int OFF_W       = 5,
  parameter int IDX_W       = 5
) (
  input  logic [AW-1:0]    addr_i,
  output region_e          region_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [OFF_W-1:0] off_o
);
  localparam int WA_W      = AW - 2;
  localparam int BASE_WORD = BANK_BASE / 4;

  logic [WA_W-1:0]  waddr;
  logic [WA_W-1:0]  rel;
  logic [IDX_W-1:0] idx;

  assign waddr = addr_i[AW-1:2];
  assign rel   = waddr - WA_W'(BASE_WORD);
  assign idx   = rel[WA_W-1:OFF_W];

  always_comb begin
    region_o = RGN_NONE;
    if (addr_i[1:0] == 2'b00) begin
      if (waddr < WA_W'(BASE_WORD)) begin
        if (waddr == WA_W'(STATUS_OFS / 4))     region_o = RGN_STATUS;
        else if (waddr == WA_W'(SLOT_OFS / 4))  region_o = RGN_SLOT;
        else if (waddr == WA_W'(EVCLR_OFS / 4)) region_o = RGN_EVCLR;
      end else if (idx < IDX_W'(N)) begin
        region_o = RGN_BANK;
      end
    end
  end

  assign idx_o = idx;
  assign off_o = rel[OFF_W-1:0];
endmodule

// File: rtl/aggr_evt_tokens.sv
module aggr_evt_tokens #(
  parameter int NE = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] set_i,
  input  logic          clr_valid_i,
  input  logic [DW-1:0] clr_idx_i,
  output logic [NE-1:0] tok_o
);
  logic [NE-1:0] clr_mask;
  logic [NE-1:0] tok_q;

  for (genvar g = 0; g < NE; g++) begin : g_clr
    assign clr_mask[g] = clr_valid_i && (clr_idx_i == DW'(g));
  end

  // A set in the same cycle as a clear keeps the token.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok_q <= '0;
    else        tok_q <= (tok_q & ~clr_mask) | set_i;
  end

  assign tok_o = tok_q;

  p_tok_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((tok_o & $past(set_i)) == $past(set_i)));
  p_tok_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & ~set_i) != '0) |=> ((tok_o & $past(clr_mask & ~set_i)) == '0));
endmodule

// File: rtl/thread_irq_aggregator.sv
module thread_irq_aggregator
  import aggr_pkg::*;
#(
  parameter int N           = 24,
  parameter int NE          = 32,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SLOT_W      = 16,
  parameter int BANK_BASE   = 'h100,
  parameter int BANK_STRIDE = 'h80,
  localparam int OFF_W      = $clog2(BANK_STRIDE) - 2,
  localparam int IDX_W      = ADDR_W - 2 - OFF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_data,
  input  logic [N-1:0]        thr_pend,
  output logic                irq_o,
  output logic [N-1:0]        thr_sel,
  output logic [OFF_W-1:0]    thr_off,
  output logic                thr_wr,
  input  logic [N*DATA_W-1:0] thr_rdata,
  output logic [SLOT_W-1:0]   slot_cycles,
  input  logic [NE-1:0]       evt_set,
  output logic [NE-1:0]       evt_tok
);
  region_e          region;
  logic [IDX_W-1:0] bank_idx;
  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0] rd_mux;
  logic             fire;
  logic             rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [SLOT_W-1:0] slot_q;

  aggr_irq_collect #(.N(N), .DW(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .thr_pend(thr_pend),
    .status_o(status_w), .irq_o(irq_o)
  );

  aggr_win_decode #(
    .N(N), .AW(ADDR_W), .BANK_BASE(BANK_BASE), .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) u_dec (
    .addr_i(req_addr), .region_o(region), .idx_o(bank_idx), .off_o(thr_off)
  );

  aggr_evt_tokens #(.NE(NE), .DW(DATA_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(evt_set),
    .clr_valid_i(fire && req_write && region == RGN_EVCLR),
    .clr_idx_i(req_wdata), .tok_o(evt_tok)
  );

  assign req_ready = !rsp_valid_q;
  assign fire      = req_valid && req_ready;

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign thr_sel[g] = fire && region == RGN_BANK && bank_idx == IDX_W'(g);
  end
  assign thr_wr = fire && req_write && region == RGN_BANK;

  always_comb begin
    bank_rd = '0;
    for (int t = 0; t < N; t++) begin
      if (bank_idx == IDX_W'(t)) bank_rd = thr_rdata[t*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    case (region)
      RGN_STATUS: rd_mux = status_w;
      RGN_SLOT:   rd_mux = DATA_W'(slot_q);
      RGN_BANK:   rd_mux = bank_rd;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (fire && !req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_mux;
    end else if (rsp_valid_q && rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else if (fire && req_write && region == RGN_SLOT) slot_q <= req_wdata[SLOT_W-1:0];
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_data    = rsp_data_q;
  assign slot_cycles = slot_q;

  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(thr_sel));
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  p_wr_no_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid);
  p_slot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write && region == RGN_SLOT) |=> $stable(slot_cycles));
endmodule

// File: tb/thread_irq_aggregator_test.sv
module thread_irq_aggregator_test;
  localparam int N  = 24;
  localparam int NE = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [N-1:0] thr_pend = '0;
  logic [N*32-1:0] thr_rdata = '0;
  logic [NE-1:0] evt_set = '0;
  logic req_ready, rsp_valid, irq_o, thr_wr;
  logic [31:0] rsp_data;
  logic [N-1:0] thr_sel;
  logic [4:0] thr_off;
  logic [15:0] slot_cycles;
  logic [NE-1:0] evt_tok;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_slot = '0;
  logic [NE-1:0] m_tok = '0;

  always #10 clk = ~clk;

  thread_irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .thr_pend(thr_pend), .irq_o(irq_o), .thr_sel(thr_sel), .thr_off(thr_off),
    .thr_wr(thr_wr), .thr_rdata(thr_rdata), .slot_cycles(slot_cycles),
    .evt_set(evt_set), .evt_tok(evt_tok)
  );

  function automatic logic [31:0] exp_status(input logic [N-1:0] p);
    return ~(32'(p));
  endfunction

  function automatic logic [11:0] bank_addr(input int t, input int w);
    return 12'(32'h100 + t * 32'h80 + w * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [11:0] a, input logic [31:0] exp,
                         input logic [N-1:0] esel, input bit hold, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1;
    chk({tag, " R9 ready"}, 32'(req_ready), 32'd1);
    chk({tag, " R7 sel"}, 32'(thr_sel), 32'(esel));
    if (esel != '0) chk({tag, " R7 off"}, 32'(thr_off), 32'(a[6:2]));
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R9 valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " R9 busy"}, 32'(req_ready), 32'd0);
    chk({tag, " data"}, rsp_data, exp);
    if (hold) begin
      @(negedge clk);
      chk({tag, " R9 hold"}, rsp_data, exp);
      chk({tag, " R9 held"}, 32'(rsp_valid), 32'd1);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk({tag, " R9 drained"}, 32'(rsp_valid), 32'd0);
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                          input logic [N-1:0] esel, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    #1;
    chk({tag, " R7 wsel"}, 32'(thr_sel), 32'(esel));
    chk({tag, " R7 wr"}, 32'(thr_wr), 32'(esel != '0));
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk({tag, " R9 no rsp"}, 32'(rsp_valid), 32'd0);
  endtask

  task automatic set_pend(input logic [N-1:0] p);
    @(negedge clk);
    thr_pend = p;
    @(negedge clk);
    chk("R2 irq", 32'(irq_o), 32'(p != '0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int t = 0; t < N; t++) thr_rdata[t*32 +: 32] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 irq", 32'(irq_o), 0);
    chk("R3 rsp", 32'(rsp_valid), 0);
    chk("R3 ready", 32'(req_ready), 1);
    chk("R3 slot", 32'(slot_cycles), 0);
    chk("R3 tok", evt_tok, 0);
    do_read(12'h010, 32'hFFFF_FFFF, '0, 1'b0, "R1 idle status");

    // directed status / irq patterns
    set_pend(24'h000001);
    do_read(12'h010, exp_status(24'h000001), '0, 1'b1, "R1 bit0");
    set_pend(24'h800000);
    do_read(12'h010, exp_status(24'h800000), '0, 1'b0, "R1 top bit");
    do_write(12'h010, 32'hFFFF_FFFF, '0, "R10 status write");
    chk("R10 irq kept", 32'(irq_o), 1);
    do_read(12'h010, exp_status(24'h800000), '0, 1'b0, "R10 status kept");
    set_pend('0);
    do_read(12'h010, 32'hFFFF_FFFF, '0, 1'b0, "R1 cleared");

    // slot register
    do_write(12'h030, 32'hABCD_3200, '0, "R4 slot wr");
    m_slot = 16'h3200;
    chk("R4 slot out", 32'(slot_cycles), 32'(m_slot));
    do_read(12'h030, 32'(m_slot), '0, 1'b0, "R4 slot rd");

    // unmapped
    do_write(12'h034, 32'h1111, '0, "R8 global hole");
    do_write(12'h032, 32'h2222, '0, "R8 misaligned");
    do_write(12'hD00, 32'h3333, '0, "R8 past banks");
    chk("R8 slot kept", 32'(slot_cycles), 32'(m_slot));
    do_read(12'h000, 0, '0, 1'b0, "R8 rd 0x000");
    do_read(12'h0FC, 0, '0, 1'b0, "R8 rd 0x0FC");
    do_read(12'hD00, 0, '0, 1'b0, "R8 rd past");
    do_read(12'h131, 0, '0, 1'b0, "R8 rd misaligned");
    do_read(12'h068, 0, '0, 1'b0, "R5 evclr reads 0");

    // bank edges
    do_read(bank_addr(0, 0), thr_rdata[31:0], N'(1), 1'b0, "R7 first bank");
    do_read(bank_addr(N-1, 31), thr_rdata[(N-1)*32 +: 32], N'(1) << (N-1), 1'b0, "R7 last bank");
    do_write(bank_addr(5, 7), 32'h55, N'(1) << 5, "R7 bank wr");

    // tokens
    @(negedge clk); evt_set = 32'hF0F0_000F; m_tok |= evt_set;
    @(negedge clk); evt_set = '0;
    chk("R6 tok set", evt_tok, m_tok);
    do_write(12'h068, 32'd2, '0, "R5 clr");
    m_tok[2] = 1'b0;
    chk("R5 tok clr", evt_tok, m_tok);
    do_write(12'h068, 32'd40, '0, "R5 clr range");
    chk("R5 out of range", evt_tok, m_tok);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h068; req_wdata = 32'd3;
    evt_set = 32'h8;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; evt_set = '0;
    chk("R5 set wins", evt_tok, m_tok);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: begin
          logic [N-1:0] p;
          p = N'($urandom);
          if ($urandom_range(0, 3) == 0) p = '0;
          set_pend(p);
          do_read(12'h010, exp_status(p), '0, 1'b0, "R1 rnd status");
        end
        1: begin
          logic [31:0] d;
          d = $urandom;
          do_write(12'h030, d, '0, "R4 rnd wr");
          m_slot = d[15:0];
          do_read(12'h030, 32'(m_slot), '0, 1'b0, "R4 rnd rd");
        end
        2: begin
          int t, w;
          t = int'($urandom_range(0, N-1));
          w = int'($urandom_range(0, 31));
          do_read(bank_addr(t, w), thr_rdata[t*32 +: 32], N'(1) << t, 1'b0, "R7 rnd bank");
        end
        3: begin
          @(negedge clk); evt_set = $urandom; m_tok |= evt_set;
          @(negedge clk); evt_set = '0;
          chk("R6 rnd set", evt_tok, m_tok);
        end
        default: begin
          int k;
          k = int'($urandom_range(0, NE + 7));
          do_write(12'h068, 32'(k), '0, "R5 rnd clr");
          if (k < NE) m_tok[k] = 1'b0;
          chk("R5 rnd tok", evt_tok, m_tok);
        end
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule